// File: doc/BRIEF.md
# Asymmetric Decode Slot Steering

This block sits between a pre-decode queue and a bank of parallel decoders. Each cycle it looks at the oldest few instructions in the queue. Every instruction carries three tags: how many micro-ops it expands to, whether it is long, and whether it may use a simple slot. From these the block builds one decode group for the cycle. Slot 0 is the one complex slot, and it can accept an instruction of up to `CX_UOPS` micro-ops (4, 3 or 2). The remaining slots each accept only a short, eligible, single-micro-op instruction.

Assignment follows program order. Window entry k can only land in slot k, and the first instruction that does not fit closes the group. When the oldest instruction expands beyond the complex slot's limit, it goes alone to the microcode sequencer. The block then holds every slot idle until the sequencer reports completion. The consumed count tells the upstream queue how many entries to pop.

Top module: `decsteer`

## Requirements
- R1: Slot 0 is valid exactly when window entry 0 is valid, no microcode routine is in progress, and entry 0's micro-op count (3-bit field, any value 0 to `CX_UOPS`) does not exceed `CX_UOPS`.
- R2: Slot k, for k of 1 or more, is valid only if entry k has a micro-op count of exactly 1, its long flag is 0 and its simple-eligible flag is 1.
- R3: When entry 0 is valid, no routine is in progress and its count exceeds `CX_UOPS`, `ucode_start` is 1 for that cycle, no slot is valid and the consumed count is 1.
- R4: Slot k always carries window index k (`slot_idx` field k, `IDX_W` bits at position k*`IDX_W`), and the slot-valid bits form a contiguous run starting at slot 0.
- R5: The first entry that cannot take its slot ends the group. This includes an invalid entry, a multi-op, long or ineligible entry at slot 1 or above, and a microcode-length entry that is not the oldest. No younger entry is assigned in that cycle.
- R6: From the cycle after `ucode_start` until the cycle in which `ucode_done` is high (inclusive), no slot is valid, the consumed count is 0 and `ucode_start` stays 0. Normal steering resumes on the following cycle.
- R7: When entry 0 is not valid, no slot is valid, `ucode_start` is 0 and the consumed count is 0.
- R8: The consumed count equals the number of valid slots plus 1 when `ucode_start` is high.
- R9: Reset clears any microcode routine in progress, so steering is live on the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_valid | input | NSLOT | Entry k holds an instruction (bit k, entry 0 oldest) |
| win_uops | input | NSLOT*3 | Micro-op count of entry k in bits [3k+2:3k] |
| win_long | input | NSLOT | Entry k is a long instruction |
| win_simple_ok | input | NSLOT | Entry k may use a simple slot |
| ucode_done | input | 1 | Sequencer has finished the routine it was given |
| slot_valid | output | NSLOT | Slot k is assigned this cycle |
| slot_idx | output | NSLOT*IDX_W | Window index carried by slot k |
| consumed | output | CNT_W | Entries to pop from the queue this cycle |
| ucode_start | output | 1 | Entry 0 is handed to the microcode sequencer this cycle |

## Verification
The assertions check the cycle-level invariants on every cycle. These are the contiguous slot run, consumed equal to the sum of assignments, the eligibility of every simple slot, the microcode cycle being exclusive with slot assignments, and the complete stall while a routine is in progress. None of these checks can show that a group is as large as the rules allow. Group length, the exact point where a group stops, and recovery one cycle after done and after reset are shown only by the bench. It sweeps every combination of eight instruction classes over the four window entries and compares each result with an arithmetic model.

// File: rtl/decsteer_pkg.sv
package decsteer_pkg;
  localparam int UOP_W = 3;

  // Entry may sit in a single-op slot
  function automatic logic fits_simple(input logic [UOP_W-1:0] uops,
                                       input logic lng, input logic ok);
    return (uops == UOP_W'(1)) && !lng && ok;
  endfunction

  // Entry fits the complex slot for a given micro-op limit
  function automatic logic fits_complex(input logic [UOP_W-1:0] uops,
                                        input int unsigned limit);
    return 32'(uops) <= limit;
  endfunction

  // Number of set bits in a slot vector
  function automatic int unsigned ones(input logic [31:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) c += 32'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/decsteer_classify.sv
module decsteer_classify
  import decsteer_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int CX_UOPS = 4
) (
  input  logic [NSLOT*UOP_W-1:0] uops,
  input  logic [NSLOT-1:0]       lng,
  input  logic [NSLOT-1:0]       ok,
  output logic [NSLOT-1:0]       can_simple,
  output logic                   can_complex0,
  output logic                   needs_ucode0
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_ent
    assign can_simple[k] = fits_simple(uops[k*UOP_W +: UOP_W], lng[k], ok[k]);
  end
  assign can_complex0 = fits_complex(uops[UOP_W-1:0], CX_UOPS);
  assign needs_ucode0 = !can_complex0;
endmodule

// File: rtl/decsteer_group.sv
module decsteer_group
  import decsteer_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int CNT_W = 3
) (
  input  logic             stall,
  input  logic [NSLOT-1:0] valid,
  input  logic [NSLOT-1:0] can_simple,
  input  logic             can_complex0,
  input  logic             needs_ucode0,
  output logic [NSLOT-1:0] slot_valid,
  output logic             ucode_hit,
  output logic [CNT_W-1:0] consumed
);
  logic [NSLOT:0] chain;

  assign chain[0] = !stall && valid[0] && can_complex0;
  assign slot_valid[0] = chain[0];
  for (genvar k = 1; k < NSLOT; k++) begin : g_chain
    assign chain[k] = chain[k-1] && valid[k] && can_simple[k];
    assign slot_valid[k] = chain[k];
  end
  assign chain[NSLOT] = 1'b0;

  assign ucode_hit = !stall && valid[0] && needs_ucode0;
  assign consumed  = CNT_W'(ones(32'(slot_valid), NSLOT) + 32'(ucode_hit));
endmodule

// File: rtl/decsteer_ucode_fsm.sv
module decsteer_ucode_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic busy_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_q <= 1'b0;
    else if (busy_q) busy_q <= !done;
    else             busy_q <= start;
  end
endmodule

// File: rtl/decsteer.sv
module decsteer
  import decsteer_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int CX_UOPS = 4,
  localparam int IDX_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CNT_W  = $clog2(NSLOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       win_valid,
  input  logic [NSLOT*UOP_W-1:0] win_uops,
  input  logic [NSLOT-1:0]       win_long,
  input  logic [NSLOT-1:0]       win_simple_ok,
  input  logic                   ucode_done,
  output logic [NSLOT-1:0]       slot_valid,
  output logic [NSLOT*IDX_W-1:0] slot_idx,
  output logic [CNT_W-1:0]       consumed,
  output logic                   ucode_start
);
  logic [NSLOT-1:0] can_simple;
  logic             can_complex0;
  logic             needs_ucode0;
  logic             busy_q;
  logic             ucode_hit;

  decsteer_classify #(.NSLOT(NSLOT), .CX_UOPS(CX_UOPS)) u_cls (
    .uops(win_uops), .lng(win_long), .ok(win_simple_ok),
    .can_simple(can_simple), .can_complex0(can_complex0),
    .needs_ucode0(needs_ucode0)
  );

  decsteer_group #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_grp (
    .stall(busy_q), .valid(win_valid), .can_simple(can_simple),
    .can_complex0(can_complex0), .needs_ucode0(needs_ucode0),
    .slot_valid(slot_valid), .ucode_hit(ucode_hit), .consumed(consumed)
  );

  decsteer_ucode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(ucode_hit), .done(ucode_done),
    .busy_q(busy_q)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_idx
    assign slot_idx[k*IDX_W +: IDX_W] = IDX_W'(k);
  end

  assign ucode_start = ucode_hit;
endmodule

// File: rtl/decsteer_checker.sv
module decsteer_checker
  import decsteer_pkg::*;
#(
  parameter int NSLOT   = 4,
  parameter int CX_UOPS = 4,
  parameter int CNT_W   = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NSLOT-1:0]       win_valid,
  input logic [NSLOT*UOP_W-1:0] win_uops,
  input logic [NSLOT-1:0]       win_long,
  input logic [NSLOT-1:0]       win_simple_ok,
  input logic [NSLOT-1:0]       slot_valid,
  input logic [CNT_W-1:0]       consumed,
  input logic                   ucode_start,
  input logic                   busy_q
);
  initial begin
    AST_LEGAL_LIMIT: assert (CX_UOPS >= 2 && CX_UOPS <= 4); // R1
  end

  AST_SLOT0_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid[0] |-> (win_valid[0] && 32'(win_uops[UOP_W-1:0]) <= CX_UOPS)); // R1

  for (genvar k = 1; k < NSLOT; k++) begin : g_simple
    AST_SIMPLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[k] |-> (win_valid[k] && win_uops[k*UOP_W +: UOP_W] == UOP_W'(1)
                         && !win_long[k] && win_simple_ok[k])); // R2
    AST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[k] |-> slot_valid[k-1]); // R4
  end

  AST_UCODE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_start |-> (slot_valid == '0 && consumed == CNT_W'(1))); // R3
  AST_UCODE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_start |=> busy_q); // R6
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (slot_valid == '0 && consumed == '0 && !ucode_start)); // R6
  AST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid[0] |-> (consumed == '0 && !ucode_start)); // R7
  AST_CONSUMED_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    32'(consumed) == $countones(slot_valid) + 32'(ucode_start)); // R8
endmodule

bind decsteer decsteer_checker #(.NSLOT(NSLOT), .CX_UOPS(CX_UOPS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_uops(win_uops),
  .win_long(win_long), .win_simple_ok(win_simple_ok), .slot_valid(slot_valid),
  .consumed(consumed), .ucode_start(ucode_start), .busy_q(busy_q)
);

// File: tb/decsteer_bench.sv
module decsteer_bench;
  localparam int N  = 4;
  localparam int CX = 4;
  localparam int IW = 2;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  win_valid = '0;
  logic [N*3-1:0] win_uops = '0;
  logic [N-1:0]  win_long = '0;
  logic [N-1:0]  win_simple_ok = '0;
  logic          ucode_done = 1'b0;
  logic [N-1:0]  slot_valid;
  logic [N*IW-1:0] slot_idx;
  logic [CW-1:0] consumed;
  logic          ucode_start;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  decsteer #(.NSLOT(N), .CX_UOPS(CX)) u_decsteer (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_uops(win_uops),
    .win_long(win_long), .win_simple_ok(win_simple_ok), .ucode_done(ucode_done),
    .slot_valid(slot_valid), .slot_idx(slot_idx), .consumed(consumed),
    .ucode_start(ucode_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Class codes: 0 empty, 1 simple single, 2 long single, 3 ineligible single,
  // 4/5/6/7 have 2/3/4/5 micro-ops
  function automatic int cls_uops(input int c);
    return (c <= 3) ? 1 : c - 2;
  endfunction

  task automatic load(input int code);
    for (int k = 0; k < N; k++) begin
      int c;
      c = (code >> (3 * k)) & 7;
      win_valid[k]        = (c != 0);
      win_uops[k*3 +: 3]  = 3'(cls_uops(c));
      win_long[k]         = (c == 2);
      win_simple_ok[k]    = (c != 3);
    end
  endtask

  task automatic expect_stall(input string tag);
    check(slot_valid == '0, tag, int'(slot_valid), 0);
    check(consumed == '0, tag, int'(consumed), 0);
    check(!ucode_start, tag, int'(ucode_start), 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", wd, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #4;
    expect_stall("R7 reset empty");
    rst_n = 1'b1;

    // Reset during a microcode routine (R9)
    @(negedge clk);
    load(7);
    #4;
    check(ucode_start, "R3 ucode entry", int'(ucode_start), 1);
    @(negedge clk);
    #4;
    expect_stall("R6 busy before reset");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    load(1 | (1 << 3));
    #4;
    check(slot_valid == 4'b0011, "R9 live after reset", int'(slot_valid), 3);

    // Slot index fields (R4)
    for (int k = 0; k < N; k++)
      check(slot_idx[k*IW +: IW] == IW'(k), "R4 slot index", int'(slot_idx[k*IW +: IW]), k);

    // Sweep all class combinations
    for (int code = 0; code < 4096; code++) begin
      int c[N];
      int exp_n;
      bit exp_uc;
      logic [N-1:0] exp_sv;
      @(negedge clk);
      load(code);
      for (int k = 0; k < N; k++) c[k] = (code >> (3 * k)) & 7;
      exp_n = 0;
      exp_uc = 0;
      if (c[0] != 0) begin
        if (cls_uops(c[0]) > CX) exp_uc = 1;
        else begin
          exp_n = 1;
          while (exp_n < N && c[exp_n] == 1) exp_n++;
        end
      end
      exp_sv = '0;
      for (int k = 0; k < exp_n; k++) exp_sv[k] = 1'b1;
      #4;
      if (c[0] == 0) begin
        check(slot_valid == '0 && consumed == '0, "R7 empty window", int'(consumed), 0);
      end else if (exp_uc) begin
        check(ucode_start, "R3 ucode start", int'(ucode_start), 1);
        check(slot_valid == '0, "R3 no slots", int'(slot_valid), 0);
        check(consumed == CW'(1), "R3 consumed", int'(consumed), 1);
      end else begin
        check(slot_valid[0], "R1 complex slot", int'(slot_valid[0]), 1);
        check(slot_valid == exp_sv, "R2 R5 group shape", int'(slot_valid), int'(exp_sv));
        check(!ucode_start, "R5 no ucode", int'(ucode_start), 0);
      end
      check(int'(consumed) == exp_n + int'(exp_uc), "R8 consumed", int'(consumed), exp_n + int'(exp_uc));
      if (exp_uc) begin
        @(negedge clk);
        #4;
        expect_stall("R6 busy stall");
        @(negedge clk);
        ucode_done = 1'b1;
        #4;
        expect_stall("R6 done cycle");
        @(negedge clk);
        ucode_done = 1'b0;
        load(1 | (1 << 3) | (1 << 6) | (1 << 9));
        #4;
        check(slot_valid == 4'b1111, "R6 resume", int'(slot_valid), 15);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule